// File: doc/BRIEF.md
# Multi-Cycle Word-Addressed Processor Core

This block is a compact 32-bit processor core that steps through every instruction in a fixed sequence. It fetches the word at the program counter from a synchronous, word-addressed memory and holds it as the current instruction. It then decodes the instruction, does the work, and writes back the result. The core has no pipeline. Every memory transfer goes through an internal address latch and an internal data latch. Six 32-bit general registers hold operands. An arithmetic and compare unit with its own status register handles addition, subtraction and comparison.

Two instruction layouts are decoded: a three-register form and a register-plus-16-bit-immediate form. The operations supported are:
- constant move
- add
- subtract
- compare
- unconditional jump
- load
- store

A word the core does not recognise, or a word that names a register that does not exist, still passes through the full cycle. It only advances the program counter. The outcome of the most recent compare is visible on a three-bit port.

Top module: `mc_core`

## Requirements
- R1: Reset clears the program counter, all six registers and the compare flags to zero. In the first cycle after reset the core requests a read at address 0, with the write strobe low.
- R2: Every instruction begins with a one-cycle read request at the program counter. The word returned on the read-data port in the following cycle becomes the instruction. Opcode sits in bits [31:26], the destination or single register in [25:21], the first source in [20:16], the second source in [15:11] and the immediate in [20:5].
- R3: Opcode 12 writes the 16-bit immediate, zero-extended, into the register named in [25:21].
- R4: Opcode 13 writes the 32-bit sum of the two source registers, modulo 2^32, into the destination register.
- R5: Opcode 14 writes the first source minus the second source, modulo 2^32, into the destination register.
- R6: Opcode 15 compares the two source registers as unsigned numbers. It sets exactly one flag: bit 2 for greater, bit 1 for less, bit 0 for equal. No other instruction changes the flags.
- R7: Opcode 16 makes the next fetch come from the zero-extended 16-bit immediate.
- R8: Opcode 17 reads the word at the zero-extended immediate into the named register. Its read request comes three cycles after the fetch request, and the next fetch comes six cycles after its own fetch.
- R9: Opcode 18 writes the named register to the zero-extended immediate address with a single one-cycle write strobe.
- R10: Every instruction other than a jump advances the program counter by one. A non-load instruction spans five cycles from fetch request to fetch request.
- R11: The following instructions act as no-ops: an unknown opcode, opcode 19, a nonzero function field (bits [10:0] for the three-register form, bits [4:0] for the immediate form), or a register index of 6 or above in any field the operation uses. A no-op writes no register, writes no memory, leaves the flags alone and advances the program counter by one.
- R12: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Word address for the current memory request |
| mem_wdata | output | 32 | Data to be written when the write strobe is high |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| cmp_flags | output | 3 | Result of the last compare: greater, less, equal |

## Verification
The hardest behaviour to observe from the ports is the absence of an effect. A no-op or a skipped instruction must leave the registers and flags untouched, yet the registers have no direct output. The test program therefore makes each suspect instruction target a register, or a flag setting, that a later store exposes on the write port together with the flags. Every memory write is matched against a queue of expected writes, so any stray write after a jump or a malformed instruction fails on the spot. Read-request cycles are logged to confirm the five- and six-cycle instruction spacing.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 6;
    localparam int RIDX_W    = 5;
    localparam int IMM_W     = 16;
    localparam int FLAG_W    = 3;

    localparam int OPC_LSB   = 26;
    localparam int RD_LSB    = 21;
    localparam int RS1_LSB   = 16;
    localparam int RS2_LSB   = 11;
    localparam int IMM_LSB   = 5;

    localparam int FLAG_GT   = 2;
    localparam int FLAG_LT   = 1;
    localparam int FLAG_EQ   = 0;

    typedef enum logic [OPC_W-1:0] {
        OPC_MOVI  = 6'd12,
        OPC_ADD   = 6'd13,
        OPC_SUB   = 6'd14,
        OPC_CMP   = 6'd15,
        OPC_JMP   = 6'd16,
        OPC_LD    = 6'd17,
        OPC_ST    = 6'd18,
        OPC_FETCH = 6'd19
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_WAIT,
        ST_DECODE,
        ST_EXEC,
        ST_MEM_WAIT,
        ST_WRITEBACK
    } state_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_MOVI,
        K_ADD,
        K_SUB,
        K_CMP,
        K_JMP,
        K_LD,
        K_ST
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
        logic [IMM_W-1:0]  imm;
    } dec_t;

endpackage

// File: rtl/mc_decoder.sv
module mc_decoder
    import mc_core_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic [OPC_W-1:0] opc;
    logic             rfunct_zero;
    logic             ifunct_zero;
    logic             rd_ok;
    logic             rs1_ok;
    logic             rs2_ok;

    always_comb begin
        opc         = instr[OPC_LSB +: OPC_W];
        dec.rd      = instr[RD_LSB  +: RIDX_W];
        dec.rs1     = instr[RS1_LSB +: RIDX_W];
        dec.rs2     = instr[RS2_LSB +: RIDX_W];
        dec.imm     = instr[IMM_LSB +: IMM_W];
        rfunct_zero = (instr[RS2_LSB-1:0] == '0);
        ifunct_zero = (instr[IMM_LSB-1:0] == '0);
        rd_ok       = (32'(dec.rd)  < NUM_REGS);
        rs1_ok      = (32'(dec.rs1) < NUM_REGS);
        rs2_ok      = (32'(dec.rs2) < NUM_REGS);

        dec.kind = K_NOP;
        case (opc)
            OPC_MOVI: if (ifunct_zero && rd_ok)                     dec.kind = K_MOVI;
            OPC_ADD:  if (rfunct_zero && rd_ok && rs1_ok && rs2_ok) dec.kind = K_ADD;
            OPC_SUB:  if (rfunct_zero && rd_ok && rs1_ok && rs2_ok) dec.kind = K_SUB;
            OPC_CMP:  if (rfunct_zero && rs1_ok && rs2_ok)          dec.kind = K_CMP;
            OPC_JMP:  if (ifunct_zero)                              dec.kind = K_JMP;
            OPC_LD:   if (ifunct_zero && rd_ok)                     dec.kind = K_LD;
            OPC_ST:   if (ifunct_zero && rd_ok)                     dec.kind = K_ST;
            default:  dec.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_core_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int WIDTH    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rb_idx,
    output logic [WIDTH-1:0]  ra_data,
    output logic [WIDTH-1:0]  rb_data,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0]  wr_data
);

    logic [WIDTH-1:0] regs_q [NUM_REGS];
    logic [WIDTH-1:0] regs_d [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (32'(wr_idx) == g)) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        ra_data = '0;
        rb_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (32'(ra_idx) == i) ra_data = regs_q[i];
            if (32'(rb_idx) == i) rb_data = regs_q[i];
        end
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic              do_sub,
    input  logic              flag_en,
    output logic [WIDTH-1:0]  result,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] flags_d;
    logic [FLAG_W-1:0] flags_q;

    always_comb begin
        result  = do_sub ? (op_a - op_b) : (op_a + op_b);
        flags_d = flags_q;
        if (flag_en) begin
            flags_d          = '0;
            flags_d[FLAG_GT] = (op_a > op_b);
            flags_d[FLAG_LT] = (op_a < op_b);
            flags_d[FLAG_EQ] = (op_a == op_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_core_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int NUM_REGS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [FLAG_W-1:0] cmp_flags
);

    localparam int PAD_W = ADDR_W - IMM_W;
    localparam int VPAD_W = WORD_W - IMM_W;

    typedef struct packed {
        state_e             state;
        logic [ADDR_W-1:0]  pc;
        logic [INSTR_W-1:0] ir;
        logic [ADDR_W-1:0]  mar;
        logic [WORD_W-1:0]  mdr;
        logic [WORD_W-1:0]  result;
    } ctrl_t;

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;

    dec_t              dec;
    logic [RIDX_W-1:0] ra_idx;
    logic [WORD_W-1:0] ra_data;
    logic [WORD_W-1:0] rb_data;
    logic              rf_we;
    logic [WORD_W-1:0] rf_wdata;
    logic [WORD_W-1:0] alu_res;
    logic              alu_sub;
    logic              alu_flag_en;
    logic [ADDR_W-1:0] imm_addr;
    logic [WORD_W-1:0] imm_val;

    mc_decoder #(
        .NUM_REGS (NUM_REGS)
    ) u_dec (
        .instr (ctrl_q.ir),
        .dec   (dec)
    );

    mc_regfile #(
        .NUM_REGS (NUM_REGS),
        .WIDTH    (WORD_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (ra_idx),
        .rb_idx  (dec.rs2),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .wr_en   (rf_we),
        .wr_idx  (dec.rd),
        .wr_data (rf_wdata)
    );

    mc_alu #(
        .WIDTH (WORD_W)
    ) u_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (ra_data),
        .op_b    (rb_data),
        .do_sub  (alu_sub),
        .flag_en (alu_flag_en),
        .result  (alu_res),
        .flags   (cmp_flags)
    );

    always_comb begin
        ra_idx   = (dec.kind == K_ST) ? dec.rd : dec.rs1;
        imm_addr = {{PAD_W{1'b0}}, dec.imm};
        imm_val  = {{VPAD_W{1'b0}}, dec.imm};
        alu_sub  = (dec.kind == K_SUB);
    end

    always_comb begin
        ctrl_d      = ctrl_q;
        mem_addr    = ctrl_q.mar;
        mem_wdata   = ctrl_q.mdr;
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        alu_flag_en = 1'b0;
        rf_we       = 1'b0;
        rf_wdata    = ctrl_q.result;

        case (ctrl_q.state)
            ST_FETCH_ADDR: begin
                mem_addr     = ctrl_q.pc;
                mem_re       = 1'b1;
                ctrl_d.state = ST_FETCH_WAIT;
            end

            ST_FETCH_WAIT: begin
                ctrl_d.ir    = mem_rdata[INSTR_W-1:0];
                ctrl_d.state = ST_DECODE;
            end

            ST_DECODE: begin
                ctrl_d.mar   = imm_addr;
                ctrl_d.mdr   = ra_data;
                ctrl_d.state = ST_EXEC;
            end

            ST_EXEC: begin
                ctrl_d.state = ST_WRITEBACK;
                case (dec.kind)
                    K_MOVI: ctrl_d.result = imm_val;
                    K_ADD,
                    K_SUB:  ctrl_d.result = alu_res;
                    K_CMP:  alu_flag_en   = 1'b1;
                    K_LD: begin
                        mem_re       = 1'b1;
                        ctrl_d.state = ST_MEM_WAIT;
                    end
                    K_ST:   mem_we        = 1'b1;
                    default: ;
                endcase
            end

            ST_MEM_WAIT: begin
                ctrl_d.mdr   = mem_rdata;
                ctrl_d.state = ST_WRITEBACK;
            end

            ST_WRITEBACK: begin
                case (dec.kind)
                    K_MOVI,
                    K_ADD,
                    K_SUB: rf_we = 1'b1;
                    K_LD: begin
                        rf_we    = 1'b1;
                        rf_wdata = ctrl_q.mdr;
                    end
                    default: ;
                endcase
                if (dec.kind == K_JMP) begin
                    ctrl_d.pc = imm_addr;
                end else begin
                    ctrl_d.pc = ctrl_q.pc + ADDR_W'(1);
                end
                ctrl_d.state = ST_FETCH_ADDR;
            end

            default: ctrl_d.state = ST_FETCH_ADDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.state <= ST_FETCH_ADDR;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_core_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [FLAG_W-1:0] cmp_flags,
    input state_e            state_q,
    input logic [ADDR_W-1:0] pc_q,
    input kind_e             kind
);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R9
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R2
    fetch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_ADDR) |-> (mem_re && (mem_addr == pc_q)));

    // R2
    fetch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_ADDR) |=> (state_q == ST_FETCH_WAIT));

    // R6
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_flags));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EXEC) |=> $stable(cmp_flags));

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITEBACK && kind != K_JMP) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WRITEBACK) |=> $stable(pc_q));

    // R8
    load_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && kind == K_LD) |=> (state_q == ST_MEM_WAIT));

endmodule

bind mc_core mc_core_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .cmp_flags (cmp_flags),
    .state_q   (ctrl_q.state),
    .pc_q      (ctrl_q.pc),
    .kind      (dec.kind)
);

// File: tb/mc_core_test.sv
module mc_core_test;

    logic        clk;
    logic        rst_n;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_we;
    logic        mem_re;
    logic [2:0]  cmp_flags;

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [2:0]  flags;
        string       req;
    } wr_item_t;

    wr_item_t    exp_q[$];
    int          rd_cyc[$];
    logic [31:0] rd_adr[$];
    logic [31:0] mem [1024];

    mc_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .cmp_flags (cmp_flags)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycle <= cycle + 1;
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    function automatic logic [31:0] enc_r(int op, int rd, int rs1, int rs2);
        return {op[5:0], rd[4:0], rs1[4:0], rs2[4:0], 11'd0};
    endfunction

    function automatic logic [31:0] enc_i(int op, int r, int imm);
        return {op[5:0], r[4:0], imm[15:0], 5'd0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic expect_wr(logic [31:0] a, logic [31:0] d, logic [2:0] f, string req);
        wr_item_t it;
        it.addr  = a;
        it.data  = d;
        it.flags = f;
        it.req   = req;
        exp_q.push_back(it);
    endtask

    // monitor: pops expected writes, logs reads, checks strobe exclusivity
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_re) begin
                rd_cyc.push_back(cycle);
                rd_adr.push_back(mem_addr);
            end
            if (mem_we && mem_re) begin
                check("R12", {30'd0, mem_we, mem_re}, 32'd2, "strobes together");
            end
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check("R11", mem_addr, 32'hFFFF_FFFF, "unexpected write at addr");
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check(it.req, mem_addr, it.addr, "write address");
                    check(it.req, mem_wdata, it.data, "write data");
                    check("R6", {29'd0, cmp_flags}, {29'd0, it.flags}, "flags at store");
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        mem[10'h300] = 32'hDEAD_BEEF;
        mem[10'h301] = 32'h8000_0000;

        mem[0]  = enc_i(12, 1, 5);
        mem[1]  = enc_i(12, 2, 16'hFFFF);
        mem[2]  = enc_i(18, 1, 16'h200);
        mem[3]  = enc_i(18, 2, 16'h201);
        mem[4]  = enc_r(13, 3, 1, 2);
        mem[5]  = enc_i(18, 3, 16'h202);
        mem[6]  = enc_r(14, 4, 1, 2);
        mem[7]  = enc_i(18, 4, 16'h203);
        mem[8]  = enc_i(17, 5, 16'h300);
        mem[9]  = enc_i(18, 5, 16'h204);
        mem[10] = enc_r(15, 0, 1, 2);
        mem[11] = enc_i(18, 0, 16'h205);
        mem[12] = enc_r(15, 0, 2, 1);
        mem[13] = enc_r(13, 0, 4, 4);
        mem[14] = enc_i(18, 0, 16'h206);
        mem[15] = enc_r(15, 0, 3, 3);
        mem[16] = enc_r(63, 1, 1, 1);
        mem[17] = enc_i(12, 6, 7);
        mem[18] = enc_r(13, 1, 7, 2);
        mem[19] = enc_r(13, 1, 1, 1) | 32'd1;
        mem[20] = enc_i(19, 0, 0);
        mem[21] = enc_r(15, 0, 1, 9);
        mem[22] = enc_i(18, 1, 16'h207);
        mem[23] = enc_i(17, 2, 16'h301);
        mem[24] = enc_r(15, 0, 2, 1);
        mem[25] = enc_i(18, 2, 16'h208);
        mem[26] = enc_i(16, 0, 16'h40);
        mem[27] = enc_i(18, 1, 16'h3F0);
        mem[10'h40] = enc_i(12, 1, 16'h1234);
        mem[10'h41] = enc_i(18, 1, 16'h209);
        mem[10'h42] = enc_i(18, 8, 16'h20A);
        mem[10'h43] = enc_i(18, 5, 16'h20B);
        mem[10'h44] = enc_i(16, 0, 16'h44);

        // driver: expected write stream
        expect_wr(32'h200, 32'd5,          3'b000, "R3");
        expect_wr(32'h201, 32'h0000_FFFF, 3'b000, "R3");
        expect_wr(32'h202, 32'h0001_0004, 3'b000, "R4");
        expect_wr(32'h203, 32'hFFFF_0006, 3'b000, "R5");
        expect_wr(32'h204, 32'hDEAD_BEEF, 3'b000, "R8");
        expect_wr(32'h205, 32'd0,          3'b010, "R1");
        expect_wr(32'h206, 32'hFFFE_000C, 3'b100, "R4");
        expect_wr(32'h207, 32'd5,          3'b001, "R11");
        expect_wr(32'h208, 32'h8000_0000, 3'b100, "R6");
        expect_wr(32'h209, 32'h0000_1234, 3'b100, "R7");
        expect_wr(32'h20B, 32'hDEAD_BEEF, 3'b100, "R9");

        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: first request is a read at address 0 with flags cleared
        check("R1", {31'd0, mem_re}, 32'd1, "read strobe after reset");
        check("R1", mem_addr, 32'd0, "first fetch address");
        check("R1", {31'd0, mem_we}, 32'd0, "write strobe after reset");
        check("R1", {29'd0, cmp_flags}, 32'd0, "flags after reset");

        begin
            int wd = 0;
            while (exp_q.size() != 0 && wd < 5000) begin
                @(negedge clk);
                wd++;
            end
            if (exp_q.size() != 0) begin
                checks++;
                fails++;
                $display("FAIL R10 watchdog: actual %0d pending writes expected 0", exp_q.size());
            end
        end
        repeat (30) @(negedge clk);

        if (rd_cyc.size() >= 11) begin
            // R2 / R10: fetch spacing of five cycles
            check("R10", rd_adr[1], 32'd1, "second fetch address");
            check("R10", 32'(rd_cyc[1] - rd_cyc[0]), 32'd5, "fetch spacing");
            check("R2", rd_adr[2], 32'd2, "third fetch address");
            check("R10", 32'(rd_cyc[8] - rd_cyc[0]), 32'd40, "ninth fetch cycle");
            // R8: load read three cycles after its fetch, next fetch six after
            check("R8", rd_adr[9], 32'h300, "load read address");
            check("R8", 32'(rd_cyc[9] - rd_cyc[8]), 32'd3, "load read delay");
            check("R8", rd_adr[10], 32'd9, "fetch after load");
            check("R8", 32'(rd_cyc[10] - rd_cyc[8]), 32'd6, "load instruction length");
        end else begin
            check("R2", 32'(rd_cyc.size()), 32'd11, "read request count");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule